// File: doc/BRIEF.md
# Carry-Skip Adder

A purely combinational adder for two unsigned operands and a carry input. The operand width is divided into equal groups of bits. Within a group, the carry ripples from bit to bit through full-adder cells. Each group also has a bypass. When every bit position in the group has differing operand bits, the group would only pass its incoming carry through unchanged, so the bypass hands that incoming carry straight to the next group.

The block is meant to be placed inside a datapath wherever a sum with carry-out is needed, and no register stage is wanted. The word width and the group size are parameters. The group size must divide the word width evenly, and elaboration rejects any setting that breaks this.

Top module: `skip_adder`

## Requirements
- R1: For every input combination, `{co, s}` equals the arithmetic value `x + y + ci`. The operands are unsigned, `co` is the bit above the top bit of `s`, and `ci` has weight 1.
- R2: Each sum bit `s[i]` equals `x[i] ^ y[i] ^ k`, where `k` is the carry entering bit `i`. Inside a group that carry is the full-adder majority of the previous bit's operands and carry. For the lowest bit of a group, it is the carry handed on by the group below, or `ci` for group 0.
- R3: A group in which `x[i] != y[i]` holds for all of its bits hands its own carry-in to the next group unchanged. With all bits propagating across the word (for example `x = all ones`, `y = 0`), `ci = 1` gives `s = 0` and `co = 1`, and `ci = 0` gives `s = all ones` and `co = 0`.
- R4: A group that has at least one bit with `x[i] == y[i]` hands on the carry produced by its top full-adder cell. A carry generated inside a group therefore reaches the next group even when `ci = 0`.
- R5: `co` is the carry handed on by the most significant group. For example, adding two operands that have only the top bit set gives `s = 0` and `co = 1`.
- R6: The parameters `W` (word width) and `G` (group size) set the structure of the adder. Elaboration fails when `W` is not a multiple of `G`.
- R7: All-zero inputs give `s = 0` and `co = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | W | First operand |
| y | input | W | Second operand |
| ci | input | 1 | Carry into bit 0 |
| s | output | W | Sum |
| co | output | 1 | Carry out of the top group |

## Verification
The bench builds two copies of the adder:
- The default copy (`W = 16`, `G = 4`) has four groups. Directed patterns make one, several, or all of these groups propagate, and random operands cover the rest.
- A second copy (`W = 9`, `G = 3`) has an odd group count and a width that is not a power of two. It shows that the group indexing and the top carry stay correct when the word does not split into binary-sized pieces.

Random vectors from a fixed seed, together with the directed edges (all propagate, all generate, top bit only, zero), are compared against plain integer addition.

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int NG = W / G;

  // R6: reject a group size that does not divide the width
  if (W % G != 0) begin : g_bad_split
    $error("skip_adder: W must be a multiple of G");
  end

  logic          k;
  logic          grp_in;
  logic          grp_top;
  logic          all_p;
  logic          p;
  logic [NG-1:0] skip;

  always_comb begin
    k       = ci;
    grp_in  = 1'b0;
    grp_top = 1'b0;
    all_p   = 1'b0;
    p       = 1'b0;
    s       = '0;
    for (int g = 0; g < NG; g++) begin
      grp_in = k;
      all_p  = 1'b1;
      for (int j = 0; j < G; j++) begin
        p            = x[g*G+j] ^ y[g*G+j];
        s[g*G+j]     = p ^ k;
        a_r2_bit_sum: assert (s[g*G+j] == (x[g*G+j] ^ y[g*G+j] ^ k));
        k            = (x[g*G+j] & y[g*G+j]) | (x[g*G+j] & k) | (y[g*G+j] & k);
        all_p        = all_p & p;
      end
      grp_top = k;
      skip[g] = all_p;
      // R3: under full propagation the ripple result already equals the group input
      a_r3_skip_consistent: assert (!all_p || grp_top == grp_in);
      k = all_p ? grp_in : grp_top;
      // R4: without full propagation the handed-on carry is the top cell's
      a_r4_ripple_used: assert (all_p || k == grp_top);
    end
    co = k;
    a_r1_total: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci}));
    a_r7_zero: assert (!(x == '0 && y == '0 && !ci) || ({co, s} == '0));
  end
endmodule

// File: tb/skip_adder_tb_top.sv
`timescale 1ns/1ps
module skip_adder_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] xa, ya, sa;
  logic        cia, coa;
  logic [8:0]  xb, yb, sb;
  logic        cib, cob;

  int n_chk = 0;
  int n_bad = 0;

  skip_adder #(.W(16), .G(4)) dut_i (.x(xa), .y(ya), .ci(cia), .s(sa), .co(coa));
  skip_adder #(.W(9),  .G(3)) dut_n (.x(xb), .y(yb), .ci(cib), .s(sb), .co(cob));

  function automatic logic [16:0] ref16(logic [15:0] p, logic [15:0] q, logic c);
    return {1'b0, p} + {1'b0, q} + {16'd0, c};
  endfunction

  function automatic logic [9:0] ref9(logic [8:0] p, logic [8:0] q, logic c);
    return {1'b0, p} + {1'b0, q} + {9'd0, c};
  endfunction

  task automatic chk(string tag, logic [16:0] got, logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run16(string tag, logic [15:0] p, logic [15:0] q, logic c);
    @(posedge clk);
    xa = p; ya = q; cia = c;
    @(negedge clk);
    chk(tag, {coa, sa}, ref16(p, q, c));
  endtask

  task automatic run9(string tag, logic [8:0] p, logic [8:0] q, logic c);
    @(posedge clk);
    xb = p; yb = q; cib = c;
    @(negedge clk);
    chk(tag, {7'd0, cob, sb}, {7'd0, ref9(p, q, c)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    xa = '0; ya = '0; cia = 1'b0;
    xb = '0; yb = '0; cib = 1'b0;
    @(negedge clk);
    chk("R7 zero16", {coa, sa}, 17'd0);
    chk("R7 zero9", {7'd0, cob, sb}, 17'd0);
    run16("R3 allprop ci1", 16'hFFFF, 16'h0000, 1'b1);
    chk("R3 allprop ci1 direct", {coa, sa}, 17'h10000);
    run16("R3 allprop ci0", 16'hA5A5, 16'h5A5A, 1'b0);
    chk("R3 allprop ci0 direct", {coa, sa}, 17'h0FFFF);
    run16("R3 mid groups prop", 16'h0FF1, 16'h000F, 1'b0);
    run16("R4 gen inside group", 16'h000F, 16'h0001, 1'b0);
    chk("R4 gen inside direct", {coa, sa}, 17'h00010);
    run16("R4 all generate", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R5 top bit", 16'h8000, 16'h8000, 1'b0);
    chk("R5 top bit direct", {coa, sa}, 17'h10000);
    run16("R2 alternating", 16'h3C3C, 16'h0F0F, 1'b1);
    run9("R3 w9 allprop", 9'h1FF, 9'h000, 1'b1);
    run9("R4 w9 gen", 9'h007, 9'h001, 1'b0);
    run9("R5 w9 top", 9'h100, 9'h100, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] p, q;
      logic [15:0] m;
      p = 16'($urandom);
      m = 16'($urandom);
      q = (i % 3 == 0) ? (~p ^ (m & 16'h000F)) : 16'($urandom);
      run16("R1 random16", p, q, 1'($urandom));
    end
    for (int i = 0; i < 2000; i++) begin
      logic [8:0] p, q;
      p = 9'($urandom);
      q = (i % 4 == 0) ? ~p : 9'($urandom);
      run9("R1 random9", p, q, 1'($urandom));
    end
    // R6 is exercised by elaborating the two parameter sets above
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule